// File: doc/BRIEF.md
# Dynamic-Template Key Embedding Stream Generator

This block produces a serial bitstream that hides a secret key among pseudo-random filler bits, so that a receiver holding the same templates can authenticate against a reconfigurable test network. Once started, it emits one bit per clock. Most bits come from a 32-bit LFSR. A shift window holds the bits emitted most recently. When that window equals the selected template, the next bit emitted is the next key bit and not a random bit.

The template is not fixed. A bank of templates, eight by default, is indexed by the last few bits that were emitted, so the template in use changes as the stream runs. Emission stops right after the last key bit has been placed. The block then raises a done flag and holds it until the next start. The widths of the template, key, LFSR and counter are all parameters.

Top module: `key_embed_gen`

## Requirements
- R1: After reset, `bit_vld_o`, `busy_o`, `done_o` and `emit_cnt_o` are all zero, and the window is cleared.
- R2: `start_i` is accepted when `busy_o` is low. At that edge it captures `key_i`, loads the LFSR from `seed_i` (a seed of zero is replaced by 1), clears the window, `emit_cnt_o` and `done_o`, and raises `busy_o`. The first bit appears one edge later.
- R3: A random bit is bit 0 of the LFSR state. On that cycle the state shifts right by one, and if the bit was 1 the state is XORed with 32'h80200003. The state does not change on cycles that emit a key bit.
- R4: The window holds the emitted bits with the newest in bit 0. The template slot used for comparison is given by the window's low log2(NUM_TPL) bits, that is, the last emitted bits with the newest in bit 0.
- R5: No comparison is made until `emit_cnt_o` has reached TPL_W since the last accepted start.
- R6: When the window equals the selected template, the next emitted bit is the next key bit. Key bits are taken from bit 0 upward.
- R7: `bit_vld_o` is high for one cycle per emitted bit, on consecutive cycles while busy. `emit_cnt_o` then counts up by one per bit and saturates at its maximum.
- R8: On the edge that emits the last key bit, `busy_o` falls and `done_o` rises. `done_o` stays high until the next accepted start.
- R9: A `start_i` pulse while `busy_o` is high has no effect on the stream, the key, the seed or the counter.
- R10: A write with `tpl_wr_i` high stores `tpl_data_i` into template slot `tpl_idx_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted when idle |
| seed_i | input | LFSR_W | LFSR seed, captured at start |
| key_i | input | KEY_W | Secret key, captured at start |
| tpl_wr_i | input | 1 | Template write strobe |
| tpl_idx_i | input | SEL_W | Template slot to write |
| tpl_data_i | input | TPL_W | Template value to write |
| bit_o | output | 1 | Emitted stream bit |
| bit_vld_o | output | 1 | Qualifies `bit_o` |
| busy_o | output | 1 | Embedding in progress |
| done_o | output | 1 | All key bits embedded |
| emit_cnt_o | output | CNT_W | Bits emitted since the last start |

## Verification
The checker relies on `start_i` being the only way out of the done state, and on a run that is in progress ending only through the last key bit. It therefore assumes that the templates can actually match, so that every run finishes. The bench writes templates only while the block is idle. In each slot it sets the low index bits equal to the slot number, which keeps matches frequent with small widths. Starts are single-cycle pulses, and one of them is placed deliberately in the middle of a run to show that it is ignored.

// File: rtl/key_embed_pkg.sv
package key_embed_pkg;
   localparam logic [31:0] LFSR_MASK32 = 32'h80200003;

   function automatic logic [31:0] lfsr_step(input logic [31:0] s);
      logic [31:0] n;
      n = s >> 1;
      if (s[0]) n = n ^ LFSR_MASK32;
      return n;
   endfunction
endpackage

// File: rtl/key_embed_lfsr.sv
module key_embed_lfsr #(
   parameter int LFSR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [LFSR_W-1:0] seed_i,
   input  logic              adv_i,
   output logic              rnd_o
);
   import key_embed_pkg::*;
   logic [LFSR_W-1:0] state_q;

   generate
      if (LFSR_W != 32) begin : g_bad_w
         $error("key_embed_lfsr: only a 32-bit LFSR is provided");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= {{(LFSR_W-1){1'b0}}, 1'b1};
      end else if (load_i) begin
         state_q <= (seed_i == '0) ? {{(LFSR_W-1){1'b0}}, 1'b1} : seed_i;
      end else if (adv_i) begin
         state_q <= lfsr_step(state_q);
      end
   end

   assign rnd_o = state_q[0];
endmodule

// File: rtl/key_embed_keysel.sv
module key_embed_keysel #(
   parameter int KEY_W = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [KEY_W-1:0] key_i,
   input  logic             take_i,
   output logic             key_bit_o,
   output logic             last_o
);
   localparam int KIDX_W = (KEY_W > 1) ? $clog2(KEY_W) : 1;
   localparam logic [KIDX_W-1:0] LAST_IDX = KIDX_W'(KEY_W - 1);

   logic [KEY_W-1:0]  key_q;
   logic [KIDX_W-1:0] kidx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q  <= '0;
         kidx_q <= '0;
      end else if (load_i) begin
         key_q  <= key_i;
         kidx_q <= '0;
      end else if (take_i) begin
         key_q  <= key_q >> 1;
         if (kidx_q != LAST_IDX) kidx_q <= kidx_q + 1'b1;
      end
   end

   assign key_bit_o = key_q[0];
   assign last_o    = (kidx_q == LAST_IDX);
endmodule

// File: rtl/key_embed_tplbank.sv
module key_embed_tplbank #(
   parameter int TPL_W   = 16,
   parameter int NUM_TPL = 8,
   parameter int SEL_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [SEL_W-1:0] wr_idx_i,
   input  logic [TPL_W-1:0] wr_data_i,
   input  logic [TPL_W-1:0] win_i,
   output logic             match_o
);
   logic [TPL_W-1:0]   bank_q [NUM_TPL];
   logic [NUM_TPL-1:0] slot_hit;
   logic [SEL_W-1:0]   sel;

   for (genvar i = 0; i < NUM_TPL; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) bank_q[i] <= '0;
         else if (wr_i && wr_idx_i == SEL_W'(i)) bank_q[i] <= wr_data_i;
      end
      assign slot_hit[i] = (win_i == bank_q[i]);
   end

   generate
      if (NUM_TPL == 1) begin : g_fixed
         assign sel = '0;
      end else begin : g_dyn
         assign sel = win_i[SEL_W-1:0];
      end
   endgenerate

   assign match_o = slot_hit[sel];
endmodule

// File: rtl/key_embed_gen.sv
module key_embed_gen #(
   parameter int TPL_W   = 16,
   parameter int NUM_TPL = 8,
   parameter int KEY_W   = 256,
   parameter int LFSR_W  = 32,
   parameter int CNT_W   = 24,
   localparam int SEL_W  = (NUM_TPL > 1) ? $clog2(NUM_TPL) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [LFSR_W-1:0] seed_i,
   input  logic [KEY_W-1:0]  key_i,
   input  logic              tpl_wr_i,
   input  logic [SEL_W-1:0]  tpl_idx_i,
   input  logic [TPL_W-1:0]  tpl_data_i,
   output logic              bit_o,
   output logic              bit_vld_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [CNT_W-1:0]  emit_cnt_o
);
   generate
      if ((NUM_TPL & (NUM_TPL - 1)) != 0) begin : g_chk_pow2
         $error("key_embed_gen: NUM_TPL must be a power of two");
      end
      if (TPL_W < SEL_W) begin : g_chk_tpl
         $error("key_embed_gen: TPL_W must cover the selector bits");
      end
      if (CNT_W < 20 || (2**CNT_W) <= TPL_W) begin : g_chk_cnt
         $error("key_embed_gen: CNT_W too small");
      end
      if (KEY_W < 1) begin : g_chk_key
         $error("key_embed_gen: KEY_W must be positive");
      end
   endgenerate

   localparam logic [CNT_W-1:0] WARM_CNT = CNT_W'(TPL_W);

   logic             start_acc;
   logic [TPL_W-1:0] win_q;
   logic             warm;
   logic             tpl_match;
   logic             take_key;
   logic             rnd_bit;
   logic             key_bit;
   logic             key_last;
   logic             nxt_bit;

   assign start_acc = start_i && !busy_o;
   assign warm      = (emit_cnt_o >= WARM_CNT);
   assign take_key  = busy_o && warm && tpl_match;
   assign nxt_bit   = take_key ? key_bit : rnd_bit;

   key_embed_lfsr #(.LFSR_W(LFSR_W)) u_lfsr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (start_acc),
      .seed_i (seed_i),
      .adv_i  (busy_o && !take_key),
      .rnd_o  (rnd_bit)
   );

   key_embed_keysel #(.KEY_W(KEY_W)) u_keysel (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (start_acc),
      .key_i     (key_i),
      .take_i    (take_key),
      .key_bit_o (key_bit),
      .last_o    (key_last)
   );

   key_embed_tplbank #(.TPL_W(TPL_W), .NUM_TPL(NUM_TPL), .SEL_W(SEL_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (tpl_wr_i),
      .wr_idx_i  (tpl_idx_i),
      .wr_data_i (tpl_data_i),
      .win_i     (win_q),
      .match_o   (tpl_match)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o     <= 1'b0;
         done_o     <= 1'b0;
         bit_o      <= 1'b0;
         bit_vld_o  <= 1'b0;
         emit_cnt_o <= '0;
         win_q      <= '0;
      end else begin
         bit_vld_o <= 1'b0;
         if (start_acc) begin
            busy_o     <= 1'b1;
            done_o     <= 1'b0;
            emit_cnt_o <= '0;
            win_q      <= '0;
         end else if (busy_o) begin
            bit_o     <= nxt_bit;
            bit_vld_o <= 1'b1;
            if (TPL_W > 1) win_q <= {win_q[TPL_W-2:0], nxt_bit};
            else           win_q <= TPL_W'(nxt_bit);
            if (emit_cnt_o != '1) emit_cnt_o <= emit_cnt_o + 1'b1;
            if (take_key && key_last) begin
               busy_o <= 1'b0;
               done_o <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/key_embed_gen_chk.sv
module key_embed_gen_chk #(
   parameter int CNT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             bit_vld_o,
   input logic             busy_o,
   input logic             done_o,
   input logic [CNT_W-1:0] emit_cnt_o
);
   a_r7_vld_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      bit_vld_o |-> $past(busy_o));
   a_r7_vld_continuous: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> bit_vld_o);
   a_r7_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o) && $past(emit_cnt_o) != '1)
         |-> emit_cnt_o == $past(emit_cnt_o) + 1'b1);
   a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   a_r8_done_with_bit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> bit_vld_o);
   a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> done_o);
   a_r9_busy_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> (busy_o || done_o));
endmodule

bind key_embed_gen key_embed_gen_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .bit_vld_o  (bit_vld_o),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .emit_cnt_o (emit_cnt_o)
);

// File: tb/key_embed_gen_bench.sv
module key_embed_gen_bench;
   localparam int TPL_W   = 8;
   localparam int NUM_TPL = 8;
   localparam int KEY_W   = 16;
   localparam int CNT_W   = 20;
   localparam int SEL_W   = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [31:0]       seed_i = '0;
   logic [KEY_W-1:0]  key_i = '0;
   logic              tpl_wr_i = 1'b0;
   logic [SEL_W-1:0]  tpl_idx_i = '0;
   logic [TPL_W-1:0]  tpl_data_i = '0;
   logic              bit_o, bit_vld_o, busy_o, done_o;
   logic [CNT_W-1:0]  emit_cnt_o;

   int checks = 0;
   int errors = 0;
   int seen = 0;
   bit finished = 0;
   bit exp_q [$];
   logic [TPL_W-1:0] tpl_m [NUM_TPL];

   always #10 clk = ~clk;

   key_embed_gen #(.TPL_W(TPL_W), .NUM_TPL(NUM_TPL), .KEY_W(KEY_W),
                   .LFSR_W(32), .CNT_W(CNT_W)) u_key_embed_gen (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .seed_i(seed_i),
      .key_i(key_i), .tpl_wr_i(tpl_wr_i), .tpl_idx_i(tpl_idx_i),
      .tpl_data_i(tpl_data_i), .bit_o(bit_o), .bit_vld_o(bit_vld_o),
      .busy_o(busy_o), .done_o(done_o), .emit_cnt_o(emit_cnt_o));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_sim();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // monitor: pops expected bits as they appear (R3 R4 R5 R6 R7)
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && bit_vld_o) begin
            seen++;
            if (exp_q.size() == 0) begin
               check("R8 extra bit after last key bit", 1, 0);
            end else begin
               check("R6 stream bit (R3 R4 R5 model)", bit_o, exp_q.pop_front());
            end
            check("R7 emit count", emit_cnt_o, seen);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_sim();
   end

   task automatic write_tpl(input int idx, input logic [TPL_W-1:0] val);
      @(negedge clk);
      tpl_wr_i = 1; tpl_idx_i = SEL_W'(idx); tpl_data_i = val;
      @(negedge clk);
      tpl_wr_i = 0;
      tpl_m[idx] = val;   // R10
   endtask

   // reference model built from the requirements; returns stream length
   function automatic int build_expected(input logic [31:0] seed, input logic [KEY_W-1:0] key);
      logic [31:0] s = (seed == 0) ? 32'h1 : seed;
      logic [TPL_W-1:0] win = '0;
      int cnt = 0, k = 0;
      bit b, hit;
      exp_q.delete();
      while (k < KEY_W) begin
         hit = (cnt >= TPL_W) && (win == tpl_m[win[SEL_W-1:0]]);
         if (hit) begin
            b = key[k]; k++;
         end else begin
            b = s[0];
            s = (s >> 1) ^ (s[0] ? 32'h80200003 : 32'h0);
         end
         win = {win[TPL_W-2:0], b};
         cnt++;
         exp_q.push_back(b);
      end
      return cnt;
   endfunction

   task automatic run_case(input logic [31:0] seed, input logic [KEY_W-1:0] key,
                           input int intrude_at);
      int len = build_expected(seed, key);
      @(negedge clk);
      seen = 0;
      start_i = 1; seed_i = seed; key_i = key;
      @(negedge clk);
      start_i = 0; seed_i = 32'hDEAD_BEEF; key_i = ~key;
      check("R2 busy after start", busy_o, 1);
      check("R2 done cleared", done_o, 0);
      check("R2 count cleared", emit_cnt_o, 0);
      check("R2 no bit yet", bit_vld_o, 0);
      if (intrude_at > 0) begin
         repeat (intrude_at) @(negedge clk);
         start_i = 1; seed_i = 32'h1234_5678;   // R9: ignored while busy
         @(negedge clk);
         start_i = 0;
      end
      while (!done_o) @(negedge clk);
      check("R8 busy low at done", busy_o, 0);
      check("R8 all bits seen", exp_q.size(), 0);
      check("R7 final count", emit_cnt_o, len);
      repeat (4) @(negedge clk);
      check("R8 done held", done_o, 1);
      check("R8 no bits after done", bit_vld_o, 0);
      check("R7 count stable after done", emit_cnt_o, len);
   endtask

   initial begin
      for (int i = 0; i < NUM_TPL; i++) tpl_m[i] = '0;
      repeat (3) @(negedge clk);
      check("R1 vld after reset", bit_vld_o, 0);
      check("R1 busy after reset", busy_o, 0);
      check("R1 done after reset", done_o, 0);
      check("R1 count after reset", emit_cnt_o, 0);
      rst_n = 1;
      // low bits of each template equal its slot so matches can occur (R4)
      for (int i = 0; i < NUM_TPL; i++)
         write_tpl(i, TPL_W'((((i * 37) + 11) << SEL_W) | i));
      run_case(32'hACE1_2357, 16'hB5C3, 0);
      // R5: slot 0 all zeros would match the cleared window at once
      write_tpl(0, '0);
      for (int i = 1; i < NUM_TPL; i++)
         write_tpl(i, TPL_W'((((i * 53) + 5) << SEL_W) | i));
      run_case(32'h0, 16'h0001, 20);          // zero seed (R2), intrusion (R9)
      run_case(32'h8000_0001, 16'hFFFF, 7);   // restart from done (R8)
      run_case(32'h5A5A_0F0F, 16'h2468, 0);
      finish_sim();
   end
endmodule